// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

This block drives four pulse-width-modulated outputs, one per channel, from a single system clock. Each channel divides the clock in two stages: a prescaler that produces one tick every `pre + 1` clock cycles, and a period divider that counts `per + 1` of those ticks per output period. A third value, the high count, sets how many prescaled ticks the output stays high at the start of each period.

Software programs each channel through two 32-bit registers on a simple write-strobe register bus, with combinational read data. Divider and high-count values are first held in a staging set. They reach the running counters only after a write to the control register that carries the commit request. While a channel runs, the transfer waits for the end of the current period, so no shortened or stretched period ever appears on the pin. While a channel is stopped, the transfer happens on the next clock. The run bit in the same control register starts and stops the channel directly.

Top module: `qpwm_top`

## Requirements
- R1: Channel i owns byte offsets 8*i (data register) and 8*i+4 (control register); the bus carries byte-address bits [AW-1:2]. Data register: bits [15:0] period divider `per`, bits [31:16] high count `hi`. Control register: bits [15:0] prescaler `pre`, bits [29:16] spare storage, bit 30 commit request, bit 31 run. Every field except the commit request reads back the last value written to it.
- R2: While running with active values pre and per, the output repeats with a period of exactly (pre+1)*(per+1) clock cycles.
- R3: In each period the output is high for the first min(hi, per+1)*(pre+1) cycles and low for the rest; hi = 0 gives a constant low, and hi of per+1 or more gives a constant high.
- R4: Data-register writes, and prescaler values written with bit 30 clear, leave the output waveform unchanged until a control-register write with bit 30 set.
- R5: With the channel running, a pending commit is applied at the end of the current period: the period in progress completes with the old values, and the next one starts with the new values.
- R6: Bit 30 reads as 1 from the clock after a commit request until the transfer, then reads 0. With the run bit clear, the transfer happens on the first clock after the request.
- R7: Clearing the run bit drives the output low from the next cycle and holds it low. Setting it restarts the channel: the output stays low for one cycle, then a fresh period begins, and a commit pending at that moment is applied before that period.
- R8: The four channels are independent: a write to one channel's registers never changes another channel's output or read data.
- R9: Reset clears every register field, leaves all channels stopped and holds all outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that is also divided to make the output waveforms |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe; the write is taken on the rising clock edge |
| bus_addr | input | AW-2 | Byte-address bits [AW-1:2] selecting the channel and register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register selected by bus_addr |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
The bench builds the block with its default parameters: four channels and 16-bit divider fields. It keeps the prescaler and divider values small, so hundreds of complete periods fit into the run. These include single-cycle periods and commits that land exactly on period boundaries. Commits are also issued while a channel is stopped and in the same cycle the channel is started, and high counts at zero, inside the period and beyond its end are all reached, with all four channels active at once.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;

    localparam int QP_CW       = 16;
    localparam int QP_DW       = 32;
    localparam int QP_HI_LSB   = 16;
    localparam int QP_UPD_BIT  = 30;
    localparam int QP_EN_BIT   = 31;
    localparam int QP_SPARE_W  = QP_UPD_BIT - QP_HI_LSB;

    typedef logic [QP_CW-1:0] cnt_t;

    typedef struct packed {
        cnt_t pre;
        cnt_t per;
        cnt_t hi;
    } cfg_t;

endpackage

// File: rtl/qpwm_regs.sv
module qpwm_regs
    import qpwm_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [CHW:0]          word_addr,
    input  logic [QP_DW-1:0]      wdata,
    output logic [QP_DW-1:0]      rdata,
    output cfg_t [NCH-1:0]        stage_o,
    output logic [NCH-1:0]        run_o,
    output logic [NCH-1:0]        pend_o,
    input  logic [NCH-1:0]        commit_i
);

    typedef struct packed {
        cfg_t [NCH-1:0]                    stage;
        logic [NCH-1:0][QP_SPARE_W-1:0]    spare;
        logic [NCH-1:0]                    run;
        logic [NCH-1:0]                    pend;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [CHW-1:0] ch_sel;
    logic           ctl_sel;
    logic [NCH-1:0] hit_data, hit_ctl;

    assign ch_sel  = word_addr[CHW:1];
    assign ctl_sel = word_addr[0];

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            hit_data[i] = bus_wr && (ch_sel == CHW'(i)) && !ctl_sel;
            hit_ctl[i]  = bus_wr && (ch_sel == CHW'(i)) &&  ctl_sel;
        end
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NCH; i++) begin
            if (commit_i[i]) begin
                bank_d.pend[i] = 1'b0;
            end
            if (hit_data[i]) begin
                bank_d.stage[i].per = wdata[QP_CW-1:0];
                bank_d.stage[i].hi  = wdata[QP_HI_LSB +: QP_CW];
            end
            if (hit_ctl[i]) begin
                bank_d.stage[i].pre = wdata[QP_CW-1:0];
                bank_d.spare[i]     = wdata[QP_HI_LSB +: QP_SPARE_W];
                bank_d.run[i]       = wdata[QP_EN_BIT];
                if (wdata[QP_UPD_BIT]) begin
                    bank_d.pend[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ch_sel == CHW'(i)) begin
                if (ctl_sel) begin
                    rdata[QP_CW-1:0]                  = bank_q.stage[i].pre;
                    rdata[QP_HI_LSB +: QP_SPARE_W]    = bank_q.spare[i];
                    rdata[QP_UPD_BIT]                 = bank_q.pend[i];
                    rdata[QP_EN_BIT]                  = bank_q.run[i];
                end else begin
                    rdata[QP_CW-1:0]                  = bank_q.stage[i].per;
                    rdata[QP_HI_LSB +: QP_CW]         = bank_q.stage[i].hi;
                end
            end
        end
    end

    assign stage_o = bank_q.stage;
    assign run_o   = bank_q.run;
    assign pend_o  = bank_q.pend;

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_ctl[g] && wdata[QP_UPD_BIT]) |=> bank_q.pend[g]); // R6

        AST_IDLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_q.pend[g] && !bank_q.run[g] && !hit_ctl[g]) |=> !bank_q.pend[g]); // R6
    end

endmodule

// File: rtl/qpwm_chan.sv
module qpwm_chan
    import qpwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic pend_i,
    input  cfg_t stage_i,
    output logic commit_o,
    output logic pwm_o
);

    typedef struct packed {
        cfg_t act;
        cnt_t pcnt;
        cnt_t dcnt;
        logic live;
    } chan_t;

    chan_t st_d, st_q;
    logic  tick_end, period_end, commit;

    assign tick_end   = (st_q.pcnt == st_q.act.pre);
    assign period_end = tick_end && (st_q.dcnt == st_q.act.per);

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;
        if (!run_i) begin
            st_d.live = 1'b0;
            st_d.pcnt = '0;
            st_d.dcnt = '0;
            commit    = pend_i;
        end else if (!st_q.live) begin
            st_d.live = 1'b1;
            st_d.pcnt = '0;
            st_d.dcnt = '0;
            commit    = pend_i;
        end else begin
            if (tick_end) begin
                st_d.pcnt = '0;
                st_d.dcnt = period_end ? '0 : st_q.dcnt + 1'b1;
            end else begin
                st_d.pcnt = st_q.pcnt + 1'b1;
            end
            commit = pend_i && period_end;
        end
        if (commit) begin
            st_d.act = stage_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_o = commit;
    assign pwm_o    = run_i && st_q.live && (st_q.dcnt < st_q.act.hi);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.live |-> (st_q.pcnt <= st_q.act.pre && st_q.dcnt <= st_q.act.per)); // R2

    AST_MIDPERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && run_i && !period_end) |=> $stable(st_q.act)); // R5

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!st_q.live && st_q.pcnt == '0 && st_q.dcnt == '0)); // R7

endmodule

// File: rtl/qpwm_top.sv
module qpwm_top
    import qpwm_pkg::*;
#(
    parameter  int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int AW  = CHW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [AW-1:2]     bus_addr,
    input  logic [QP_DW-1:0]  bus_wdata,
    output logic [QP_DW-1:0]  bus_rdata,
    output logic [NCH-1:0]    pwm_out
);

    cfg_t [NCH-1:0] stage;
    logic [NCH-1:0] run, pend, commit;

    qpwm_regs #(
        .NCH (NCH),
        .CHW (CHW)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .word_addr (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .stage_o   (stage),
        .run_o     (run),
        .pend_o    (pend),
        .commit_i  (commit)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        qpwm_chan chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_i    (run[g]),
            .pend_i   (pend[g]),
            .stage_i  (stage[g]),
            .commit_o (commit[g]),
            .pwm_o    (pwm_out[g])
        );
    end

    AST_RESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pwm_out == '0)); // R9

endmodule

// File: tb/qpwm_top_tb_top.sv
module qpwm_top_tb_top;

    localparam int NCH = 4;
    localparam int AW  = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic [AW-1:2]  bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] pwm_out;

    always #5 clk = ~clk;

    qpwm_top #(.NCH(NCH)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    bit    cmp_on = 0;
    string cur_req = "R9";

    // behavioural model: staged values, active values, phase within the period
    int m_pre[NCH], m_per[NCH], m_hi[NCH], m_spare[NCH];
    int a_pre[NCH], a_per[NCH], a_hi[NCH];
    bit m_en[NCH], m_pend[NCH], m_live[NCH];
    int m_ph[NCH];

    function automatic bit exp_out(int c);
        int h;
        h = (a_hi[c] < a_per[c] + 1) ? a_hi[c] : a_per[c] + 1;
        return m_en[c] && m_live[c] && (m_ph[c] < h * (a_pre[c] + 1));
    endfunction

    function automatic logic [31:0] exp_rd(int w);
        int c;
        logic [31:0] v;
        c = w / 2;
        v = '0;
        if (w % 2 == 1) begin
            v[15:0]  = m_pre[c][15:0];
            v[29:16] = m_spare[c][13:0];
            v[30]    = m_pend[c];
            v[31]    = m_en[c];
        end else begin
            v[15:0]  = m_per[c][15:0];
            v[31:16] = m_hi[c][15:0];
        end
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_pre[c] = 0; m_per[c] = 0; m_hi[c] = 0; m_spare[c] = 0;
                a_pre[c] = 0; a_per[c] = 0; a_hi[c] = 0;
                m_en[c] = 0; m_pend[c] = 0; m_live[c] = 0; m_ph[c] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                bit take;
                take = 0;
                if (!m_en[c]) begin
                    m_live[c] = 0; m_ph[c] = 0; take = m_pend[c];
                end else if (!m_live[c]) begin
                    m_live[c] = 1; m_ph[c] = 0; take = m_pend[c];
                end else if (m_ph[c] == (a_pre[c] + 1) * (a_per[c] + 1) - 1) begin
                    m_ph[c] = 0; take = m_pend[c];
                end else begin
                    m_ph[c]++;
                end
                if (take) begin
                    a_pre[c] = m_pre[c]; a_per[c] = m_per[c]; a_hi[c] = m_hi[c];
                    m_pend[c] = 0;
                end
            end
            if (bus_wr) begin
                int c;
                c = int'(bus_addr) / 2;
                if (bus_addr[2]) begin
                    m_pre[c]   = int'(bus_wdata[15:0]);
                    m_spare[c] = int'(bus_wdata[29:16]);
                    m_en[c]    = bus_wdata[31];
                    if (bus_wdata[30]) m_pend[c] = 1;
                end else begin
                    m_per[c] = int'(bus_wdata[15:0]);
                    m_hi[c]  = int'(bus_wdata[31:16]);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && rst_n && !done) begin
            logic [NCH-1:0] eo;
            logic [31:0]    er;
            for (int c = 0; c < NCH; c++) eo[c] = exp_out(c);
            er = exp_rd(int'(bus_addr));
            n_vec++;
            if (pwm_out !== eo || bus_rdata !== er) begin
                n_fail++;
                $display("FAIL %s t=%0t pwm_out=%b expected=%b rdata=%h expected=%h",
                         cur_req, $time, pwm_out, eo, bus_rdata, er);
            end
        end
    end

    task automatic wr(input int w, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = w[2:0]; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic look(input int w);
        bus_addr = w[2:0];
        idle(1);
    endtask

    function automatic logic [31:0] dreg(int per, int hi);
        return {hi[15:0], per[15:0]};
    endfunction

    function automatic logic [31:0] creg(bit en, bit upd, int pre);
        return {en, upd, 14'h0, pre[15:0]};
    endfunction

    task automatic direct(input string tag, input bit ok, input string what);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s", tag, what);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        #1;
        direct("R9", pwm_out === '0, $sformatf("pwm_out=%b expected=0 during reset", pwm_out));
        idle(3);
        rst_n = 1'b1;
        cmp_on = 1;
        cur_req = "R9";
        for (int w = 0; w < 2 * NCH; w++) look(w);

        // R1: field placement and readback, including spare bits
        cur_req = "R1";
        wr(0, dreg(16'h1234, 16'hABCD));
        wr(1, {1'b0, 1'b0, 14'h2A5A, 16'h0007});
        for (int w = 0; w < 2 * NCH; w++) look(w);
        direct("R1", bus_rdata !== 32'hFFFF_FFFF, "readback sanity");

        // R2, R3: basic waveform on channel 0
        cur_req = "R2";
        wr(0, dreg(3, 2));
        wr(1, creg(1, 1, 1));
        look(1);
        idle(40);

        // R3: zero high count, saturated high count, single-cycle period
        cur_req = "R3";
        wr(2, dreg(4, 0));
        wr(3, creg(1, 1, 2));
        wr(4, dreg(2, 9));
        wr(5, creg(1, 1, 1));
        wr(6, dreg(0, 1));
        wr(7, creg(1, 1, 0));
        idle(40);
        wr(4, dreg(2, 3));
        wr(5, creg(1, 1, 1));
        idle(30);

        // R4: staged values without commit do not reach the output
        cur_req = "R4";
        wr(0, dreg(5, 4));
        look(0);
        idle(30);
        wr(1, creg(1, 0, 2));
        look(1);
        idle(30);

        // R5, R6: commit while running waits for the period end
        cur_req = "R5";
        wr(1, creg(1, 1, 2));
        look(1);
        idle(3);
        direct("R6", bus_rdata[30] === m_pend[0], "pending bit tracks model");
        idle(40);
        direct("R6", bus_rdata[30] === 1'b0, $sformatf("update bit=%b expected=0 after transfer", bus_rdata[30]));

        // R6, R7: commit while stopped is immediate; stop holds low
        cur_req = "R7";
        wr(0, dreg(2, 1));
        wr(1, creg(0, 1, 0));
        look(1);
        direct("R6", bus_rdata[30] === 1'b0, $sformatf("update bit=%b expected=0 while stopped", bus_rdata[30]));
        direct("R7", pwm_out[0] === 1'b0, $sformatf("pwm_out[0]=%b expected=0 when stopped", pwm_out[0]));
        idle(10);
        wr(1, creg(1, 0, 0));
        idle(20);
        // commit in the same write that starts the channel
        wr(1, creg(0, 0, 0));
        wr(0, dreg(1, 2));
        wr(1, creg(1, 1, 1));
        idle(20);

        // R8: mixed traffic across all channels
        cur_req = "R8";
        for (int k = 0; k < 600; k++) begin
            int sel, c;
            sel = $urandom_range(0, 5);
            c   = $urandom_range(0, NCH - 1);
            case (sel)
                0: wr(2 * c, dreg($urandom_range(0, 6), $urandom_range(0, 8)));
                1, 2: wr(2 * c + 1, creg($urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1,
                                         $urandom_range(0, 3)));
                3: look($urandom_range(0, 2 * NCH - 1));
                default: idle($urandom_range(0, 15));
            endcase
        end
        idle(50);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule